// File: doc/BRIEF.md
# Page-Mode Parallel ROM Reader

This block is a synchronous controller that sits between a host and an asynchronous parallel mask ROM that supports page reads. The host hands it one read at a time over a valid/ready handshake. Each read carries a byte address and a flag that picks 16-bit word or 8-bit byte access. The controller drives the ROM address pins, chip enable, output enable and width select, and in byte mode it also drives the lowest address bit onto the shared upper data pin. It then waits a fixed number of clock cycles, samples the ROM data into a register and returns it with a one-cycle valid pulse.

The controller remembers which page of the ROM is open and in which width it was opened. A page is the address with its low four byte-address bits removed. A read that lands in the open page, in the same width, waits only the short in-page count. Any other read waits the long random-access count. A flush input or a run of idle cycles closes the page. Closing raises chip enable and holds off new reads for a turnaround count, so the next read always pays the full random-access wait.

Every wait is a parameter in clock cycles. Each one is rounded up from the ROM's nanosecond figures at the chosen clock period.

Top module: `page_rom_reader`

## Requirements
- R1: A word read (`req_byte_i`=0) drives `rom_byte_no` high and `rom_addr_o` = `req_addr_i[22:1]`, leaves `rom_a_m1_oe_o` low, and returns all 16 bits of `rom_data_i` on `rsp_data_o`.
- R2: A byte read (`req_byte_i`=1) drives `rom_byte_no` low, drives `rom_a_m1_o` = `req_addr_i[0]` with `rom_a_m1_oe_o` high, and returns `{8'h00, rom_data_i[7:0]}`. `rom_data_i[15:8]` has no effect on the result.
- R3: A read that is not a page hit has `rsp_valid_o` set by the clock edge max(RAND_CYC, OE_CYC) edges after the accepting edge, for one cycle, carrying the data present at that edge.
- R4: A read is a page hit when a page is open, its `req_addr_i[22:4]` equals the open page and its width equals the open width. Its `rsp_valid_o` is set PAGE_CYC edges after the accepting edge.
- R5: From acceptance until the data sample, `rom_addr_o`, `rom_byte_no` and `rom_a_m1_o` stay constant, and `rom_ce_no` and `rom_oe_no` stay low.
- R6: A read whose width differs from the open page's width is handled as a random access (R3 timing), even when the page address matches.
- R7: `flush_i` while idle with a page open drives `rom_ce_no` high on the next edge, and the next read is random. `flush_i` in the same cycle as an accepted request makes that request random.
- R8: After IDLE_CYC consecutive idle cycles with a page open and no request, `rom_ce_no` goes high and the next read is random. A read issued sooner in the open page is still a page hit.
- R9: When chip enable is released, `req_ready_o` stays low for TURN_CYC cycles and then returns high.
- R10: During and after reset, `rom_ce_no` and `rom_oe_no` are high, `req_ready_o` is high and `rsp_valid_o` is low.
- R11: Only one read is outstanding. `req_ready_o` is low from the cycle after acceptance until the response edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | 23 | Byte address; bit 0 is used in byte mode only |
| req_byte_i | input | 1 | 1 = byte read, 0 = word read |
| flush_i | input | 1 | Close the open page |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_data_o | output | 16 | Read data |
| rom_addr_o | output | 22 | ROM address pins, word address |
| rom_a_m1_o | output | 1 | Lowest byte-address bit, driven onto the upper data pin in byte mode |
| rom_a_m1_oe_o | output | 1 | Output enable for rom_a_m1_o |
| rom_ce_no | output | 1 | ROM chip enable, active low |
| rom_oe_no | output | 1 | ROM output enable, active low |
| rom_byte_no | output | 1 | ROM width select, low = byte mode |
| rom_data_i | input | 16 | ROM data pins |

## Verification
Closing the page can meet a new request on the same clock edge. The close may come from an explicit flush or from the idle counter. The bench raises `flush_i` together with `req_valid_i` on the accepting edge of an in-page read. It judges the outcome by the response latency: the request must take the random-access count, not the page count, and the following in-page read must again be a hit. The idle case is provoked from both sides of the limit. A read issued well before expiry must still hit. After expiry, `rom_ce_no` must read high at the port, and the next read must be random.

The ROM model in the bench returns garbage until the nanosecond access time for the kind of access has passed. Any shortened wait, or any address change before the data sample, therefore shows up as wrong data.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_TURN} rd_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cyc_timer.sv
module cyc_timer #(
  parameter int unsigned MAX_CYC = 25,
  localparam int unsigned CW = $clog2(MAX_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R3
  load_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_val_i < CW'(MAX_CYC)));
endmodule

// File: rtl/page_tracker.sv
module page_tracker #(
  parameter int unsigned TAG_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [TAG_W-1:0] open_tag_i,
  input  logic             open_byte_i,
  input  logic [TAG_W-1:0] cmp_tag_i,
  input  logic             cmp_byte_i,
  input  logic             kill_i,
  output logic             hit_o,
  output logic             open_o
);
  logic             vld_q;
  logic [TAG_W-1:0] tag_q;
  logic             byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      byte_q <= 1'b0;
    end else if (open_i) begin
      vld_q  <= 1'b1;
      tag_q  <= open_tag_i;
      byte_q <= open_byte_i;
    end else if (close_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign hit_o  = vld_q && !kill_i && (tag_q == cmp_tag_i) && (byte_q == cmp_byte_i);
  assign open_o = vld_q;

  // R7
  close_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i && !open_i) |=> !open_o);
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int unsigned LIMIT = 256,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expire_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));

  // R8
  idle_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/page_rom_reader.sv
module page_rom_reader
  import rom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 23,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PAGE_BITS = 4,
  parameter int unsigned RAND_CYC  = 25,
  parameter int unsigned PAGE_CYC  = 8,
  parameter int unsigned OE_CYC    = 8,
  parameter int unsigned TURN_CYC  = 5,
  parameter int unsigned IDLE_CYC  = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_byte_i,
  input  logic              flush_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [ADDR_W-2:0] rom_addr_o,
  output logic              rom_a_m1_o,
  output logic              rom_a_m1_oe_o,
  output logic              rom_ce_no,
  output logic              rom_oe_no,
  output logic              rom_byte_no,
  input  logic [DATA_W-1:0] rom_data_i
);
  localparam int unsigned TAG_W     = ADDR_W - PAGE_BITS;
  localparam int unsigned BYTE_W    = DATA_W / 2;
  localparam int unsigned FIRST_CYC = max_u(RAND_CYC, OE_CYC);
  localparam int unsigned MAX_CYC   = max_u(max_u(FIRST_CYC, PAGE_CYC), TURN_CYC);
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);

  rd_state_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              byte_q;
  logic              ce_n_q, oe_n_q;
  logic              rsp_vld_q;
  logic [DATA_W-1:0] rsp_q;

  logic          accept, hit, pg_open, t_done, t_load, expire, close_pg, sample;
  logic [CW-1:0] t_val;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign sample      = (st_q == ST_WAIT) && t_done;
  assign close_pg    = (st_q == ST_IDLE) && !req_valid_i && !ce_n_q && (flush_i || expire);

  page_tracker #(.TAG_W(TAG_W)) u_page (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .open_i      (sample),
    .close_i     (close_pg),
    .open_tag_i  (addr_q[ADDR_W-1:PAGE_BITS]),
    .open_byte_i (byte_q),
    .cmp_tag_i   (req_addr_i[ADDR_W-1:PAGE_BITS]),
    .cmp_byte_i  (req_byte_i),
    .kill_i      (flush_i),
    .hit_o       (hit),
    .open_o      (pg_open)
  );

  idle_timer #(.LIMIT(IDLE_CYC)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    ((st_q == ST_IDLE) && pg_open && !req_valid_i),
    .expire_o (expire)
  );

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (accept) begin
      t_load = 1'b1;
      t_val  = hit ? CW'(PAGE_CYC - 1) : CW'(FIRST_CYC - 1);
    end else if (close_pg) begin
      t_load = 1'b1;
      t_val  = CW'(TURN_CYC - 1);
    end
  end

  cyc_timer #(.MAX_CYC(MAX_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .done_o     (t_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      byte_q    <= 1'b0;
      ce_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      rsp_vld_q <= 1'b0;
      rsp_q     <= '0;
    end else begin
      rsp_vld_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q <= req_addr_i;
            byte_q <= req_byte_i;
            ce_n_q <= 1'b0;
            oe_n_q <= 1'b0;
            st_q   <= ST_WAIT;
          end else if (close_pg) begin
            ce_n_q <= 1'b1;
            oe_n_q <= 1'b1;
            st_q   <= ST_TURN;
          end
        end
        ST_WAIT: begin
          if (t_done) begin
            rsp_vld_q <= 1'b1;
            rsp_q     <= byte_q ? {{(DATA_W-BYTE_W){1'b0}}, rom_data_i[BYTE_W-1:0]} : rom_data_i;
            st_q      <= ST_IDLE;
          end
        end
        ST_TURN: begin
          if (t_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rom_addr_o    = addr_q[ADDR_W-1:1];
  assign rom_a_m1_o    = byte_q && addr_q[0];
  assign rom_a_m1_oe_o = byte_q;
  assign rom_byte_no   = !byte_q;
  assign rom_ce_no     = ce_n_q;
  assign rom_oe_no     = oe_n_q;
  assign rsp_valid_o   = rsp_vld_q;
  assign rsp_data_o    = rsp_q;

  // R5
  pins_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |=> ($stable(rom_addr_o) && $stable(rom_byte_no) && $stable(rom_a_m1_o)));
  // R5
  enables_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> (!rom_ce_no && !rom_oe_no));
  // R11
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  // R3
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R9
  turn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rom_ce_no) |-> !req_ready_o);
endmodule

// File: tb/page_rom_reader_test.sv
`timescale 1ns/100ps
module page_rom_reader_test;
  localparam int RAND = 25, PAGE = 8, OE = 8, TURN = 5, IDLE = 40;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_byte = 1'b0, flush = 1'b0;
  logic [22:0] req_addr = '0;
  logic        req_ready, rsp_valid, a_m1, a_m1_oe, ce_n, oe_n, byte_n;
  logic [15:0] rsp_data, rom_data;
  logic [21:0] rom_addr;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { logic [15:0] data; int ncyc; realtime t_acc; string req; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  page_rom_reader #(.RAND_CYC(RAND), .PAGE_CYC(PAGE), .OE_CYC(OE),
                    .TURN_CYC(TURN), .IDLE_CYC(IDLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_byte_i(req_byte), .flush_i(flush),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rom_addr_o(rom_addr),
    .rom_a_m1_o(a_m1), .rom_a_m1_oe_o(a_m1_oe), .rom_ce_no(ce_n), .rom_oe_no(oe_n),
    .rom_byte_no(byte_n), .rom_data_i(rom_data));

  function automatic logic [15:0] word_val(input logic [21:0] w);
    return w[15:0] ^ {w[21:16], w[21:12]} ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] exp_data(input logic [22:0] a, input logic b);
    logic [15:0] wv;
    wv = word_val(a[22:1]);
    if (b) return {8'h00, a[0] ? wv[15:8] : wv[7:0]};
    return wv;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ROM model: garbage until the access time for the kind of change has elapsed
  initial begin
    logic [21:0] p_addr = '0;
    logic p_am1 = 1'b0, p_byte = 1'b1, p_ce = 1'b1, p_oe = 1'b1;
    real t_ok = 1.0e9, tc;
    logic [15:0] wv;
    rom_data = 16'hDEAD;
    #0.5;
    forever begin
      tc = $realtime - 0.5;
      if (ce_n) t_ok = 1.0e9;
      else begin
        if (p_ce || byte_n != p_byte || rom_addr[21:3] != p_addr[21:3]) t_ok = tc + 100.0;
        else if (rom_addr[2:0] != p_addr[2:0] || (a_m1_oe && a_m1 != p_am1))
          t_ok = (t_ok > tc + 30.0) ? t_ok : tc + 30.0;
        if (p_oe && !oe_n) t_ok = (t_ok > tc + 30.0) ? t_ok : tc + 30.0;
      end
      p_addr = rom_addr; p_am1 = a_m1; p_byte = byte_n; p_ce = ce_n; p_oe = oe_n;
      if (!ce_n && !oe_n && ($realtime + 0.5 >= t_ok)) begin
        wv = word_val(rom_addr);
        rom_data = byte_n ? wv : {1'b0, 7'h55, a_m1 ? wv[15:8] : wv[7:0]};
      end else rom_data = 16'hDEAD;
      #1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) chk(0, "R11 unexpected response", rsp_data, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(rsp_data == e.data, {e.req, " data"}, rsp_data, e.data);
        chk(int'(($realtime - e.t_acc - 2.0) / 4.0) == e.ncyc, {e.req, " latency"},
            int'(($realtime - e.t_acc - 2.0) / 4.0), e.ncyc);
      end
    end
  end

  task automatic rd(input logic [22:0] a, input logic b, input bit fl, input int n, input string req);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_byte = b; flush = fl;
    @(posedge clk);
    e.data = exp_data(a, b); e.ncyc = n; e.t_acc = $realtime; e.req = req;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b0;
    chk(req_ready == 1'b0, "R11 ready low while busy", req_ready, 0);
    chk(rom_addr == a[22:1], "R5 address pins", rom_addr, a[22:1]);
    if (b) begin
      chk(!byte_n && a_m1_oe && a_m1 == a[0], "R2 byte pins", {byte_n, a_m1_oe, a_m1}, {2'b01, a[0]});
    end else begin
      chk(byte_n && !a_m1_oe, "R1 word pins", {byte_n, a_m1_oe}, 2'b10);
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #9;
    chk(ce_n && oe_n && req_ready && !rsp_valid, "R10 in reset", {ce_n, oe_n, req_ready, rsp_valid}, 4'b1110);
    rst_n = 1'b1;
    idle(2);
    chk(ce_n && oe_n && req_ready && !rsp_valid, "R10 after reset", {ce_n, oe_n, req_ready, rsp_valid}, 4'b1110);

    rd({22'h012345, 1'b0}, 0, 0, RAND, "R1 R3 first word read");
    rd({22'h012347, 1'b0}, 0, 0, PAGE, "R4 page hit");
    rd({22'h012340, 1'b0}, 0, 0, PAGE, "R4 page hit low word");
    rd({22'h3FFFF8, 1'b0}, 0, 0, RAND, "R3 new page");
    rd({22'h3FFFFF, 1'b0}, 0, 0, PAGE, "R4 top word");
    rd({22'h3FFFFD, 1'b1}, 1, 0, RAND, "R6 width change");
    rd({22'h3FFFF8, 1'b0}, 1, 0, PAGE, "R2 R4 byte hit even");
    rd({22'h3FFFF8, 1'b1}, 1, 0, PAGE, "R2 R4 byte hit odd");
    rd({22'h3FFFF7, 1'b1}, 1, 0, RAND, "R3 adjacent page");

    // flush while idle
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(ce_n == 1'b1, "R7 flush releases chip enable", ce_n, 1);
    for (int i = 0; i < TURN - 1; i++) begin
      chk(req_ready == 1'b0, "R9 turnaround ready low", req_ready, 0);
      @(negedge clk);
    end
    chk(req_ready == 1'b0, "R9 turnaround last cycle", req_ready, 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 turnaround end", req_ready, 1);
    rd({22'h3FFFF7, 1'b0}, 1, 0, RAND, "R7 read after flush");

    // idle window
    idle(IDLE / 2);
    rd({22'h3FFFF6, 1'b1}, 1, 0, PAGE, "R8 hit before timeout");
    idle(IDLE + TURN + 4);
    chk(ce_n == 1'b1, "R8 timeout releases chip enable", ce_n, 1);
    rd({22'h3FFFF6, 1'b0}, 1, 0, RAND, "R8 read after timeout");

    // flush together with request
    rd({22'h3FFFF5, 1'b1}, 1, 1, RAND, "R7 flush with request");
    rd({22'h3FFFF4, 1'b1}, 1, 0, PAGE, "R7 page reopened");

    rd({22'h000000, 1'b0}, 0, 0, RAND, "R1 bottom word");
    rd({22'h000007, 1'b1}, 0, 0, PAGE, "R1 addr bit0 ignored in word mode");

    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule